// File: doc/BRIEF.md
# Sample-Skipping Receive Decimator

This block sits in a receive sample path, between the converter-side stream and the capture logic that feeds the host. It forwards one complex I/Q pair out of every N valid pairs and discards the others. N ranges from 1 to 8. An I value always travels with its Q value, so a pair is either kept or dropped as a whole.

The rate is chosen by a 3-bit selector, `dec_sel`. The selector holds the bitwise complement of the skip count, and the skip count is N minus one. So `111` forwards everything and `000` keeps one pair in eight. Every 3-bit code maps to a legal factor, so no out-of-range setting can reach the block. The selector may change while samples are flowing. When it changes, the counting phase restarts, so the first valid pair seen with the new code is always forwarded.

Forwarded pairs appear on registered outputs one clock after they were accepted, marked by `out_valid`.

Top module: `rx_skip_decim`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is low after that edge, and the phase count returns to zero. The first valid pair after reset is therefore forwarded.
- R2: With `dec_sel` = `111` (N = 1), every valid input pair is forwarded.
- R3: With `dec_sel` = `110` (N = 2), valid pairs alternate kept, dropped, kept, and so on, starting with kept. Two consecutive outputs are never both valid.
- R4: With `dec_sel` = `101` (N = 3), the first of every three valid pairs is forwarded and the other two are dropped.
- R5: With `dec_sel` = `000` (N = 8), the first of every eight valid pairs is forwarded and the other seven are dropped.
- R6: For any code c, N = 8 − c, where c is read as an unsigned 3-bit number. The k-th valid pair since the last phase restart (k counted from 0) is forwarded exactly when k mod N is 0.
- R7: A cycle with `in_valid` low neither advances the phase count nor produces an output. In the cycle after it, `out_valid` is low.
- R8: If `dec_sel` differs from its value in the previous cycle, the phase restarts. The valid pair in that cycle, or otherwise the next valid pair, is forwarded, and counting continues with the new N.
- R9: A forwarded pair appears exactly one clock after its acceptance. `out_i` and `out_q` carry the I and Q values of that same input pair, and `out_valid` is high in that cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present this cycle |
| in_i | input | SAMPLE_W | In-phase input value |
| in_q | input | SAMPLE_W | Quadrature input value |
| dec_sel | input | 3 | Inverted skip count selecting N = 8 − dec_sel |
| out_valid | output | 1 | Forwarded pair present on outputs |
| out_i | output | SAMPLE_W | Forwarded in-phase value |
| out_q | output | SAMPLE_W | Forwarded quadrature value |

## Verification
The four named rates run on uninterrupted valid streams. These show whether the selector inversion and the wrap point of the phase count are right. A sweep over all eight codes catches an off-by-one between code and factor that the named rates could miss. A stream with idle gaps separates a counter that counts clocks from one that counts valid pairs. Selector changes are made in the middle of a phase and in an idle cycle, to show that the phase restarts rather than carrying the old count. Every output check compares I and Q against distinct values taken from the same input pair, so a swapped or stale lane shows up.

// File: rtl/rx_skip_pkg.sv
package rx_skip_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = SEL_W;

  // The selector carries the complement of the number of pairs dropped per kept pair.
  function automatic logic [CNT_W-1:0] sel_to_skip(input logic [SEL_W-1:0] sel);
    return ~sel;
  endfunction

  // Next value of the modulo phase count: advances only on a valid pair and
  // wraps to zero once it has reached the skip count.
  function automatic logic [CNT_W-1:0] phase_next(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] skip,
                                                  input logic adv);
    if (!adv) return cnt;
    if (cnt == skip) return '0;
    return cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/rx_skip_sel_decode.sv
module rx_skip_sel_decode
  import rx_skip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] dec_sel,
  output logic [CNT_W-1:0] skip_cnt,
  output logic             sel_changed
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    sel_q <= dec_sel;
  end

  // Reset also restarts the phase, so the comparison is masked while in reset.
  assign sel_changed = !rst && (dec_sel != sel_q);
  assign skip_cnt    = sel_to_skip(dec_sel);
endmodule

// File: rtl/rx_skip_phase.sv
module rx_skip_phase
  import rx_skip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] skip_cnt,
  input  logic             restart,
  output logic             take
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_eff;

  assign cnt_eff = restart ? '0 : cnt_q;
  assign take    = in_valid && (cnt_eff == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= phase_next(cnt_eff, skip_cnt, in_valid);
  end
endmodule

// File: rtl/rx_skip_out_stage.sv
module rx_skip_out_stage #(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q
);
  localparam int LANES = 2;

  logic [LANES-1:0][SAMPLE_W-1:0] lane_d;
  logic [LANES-1:0][SAMPLE_W-1:0] lane_q;

  assign lane_d = {in_q, in_i};

  // Both lanes share one load enable so a pair is never split.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)       lane_q[g] <= '0;
      else if (take) lane_q[g] <= lane_d[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= take;
  end

  assign out_i = lane_q[0];
  assign out_q = lane_q[1];
endmodule

// File: rtl/rx_skip_decim.sv
module rx_skip_decim
  import rx_skip_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic [SEL_W-1:0]    dec_sel,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q
);
  logic [CNT_W-1:0] skip_w;
  logic             sel_changed_w;
  logic             take_w;

  rx_skip_sel_decode u_decode (
    .clk        (clk),
    .rst        (rst),
    .dec_sel    (dec_sel),
    .skip_cnt   (skip_w),
    .sel_changed(sel_changed_w)
  );

  rx_skip_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .skip_cnt(skip_w),
    .restart (sel_changed_w),
    .take    (take_w)
  );

  rx_skip_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .take     (take_w),
    .in_i     (in_i),
    .in_q     (in_q),
    .out_valid(out_valid),
    .out_i    (out_i),
    .out_q    (out_q)
  );
endmodule

// File: rtl/rx_skip_decim_chk.sv
module rx_skip_decim_chk #(
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_i,
  input logic [SAMPLE_W-1:0] in_q,
  input logic [2:0]          dec_sel,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_i,
  input logic [SAMPLE_W-1:0] out_q,
  input logic                take,
  input logic                restart
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_sel == 3'b111) |=> out_valid);

  // R3
  half_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_sel) == 3'b110 && $past(dec_sel, 2) == 3'b110) |-> !$past(out_valid));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  take_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> in_valid);

  // R8
  restart_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && in_valid) |-> take);

  // R9
  pair_data_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_i == $past(in_i) && out_q == $past(in_q) && $past(in_valid)));
endmodule

bind rx_skip_decim rx_skip_decim_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_i     (in_i),
  .in_q     (in_q),
  .dec_sel  (dec_sel),
  .out_valid(out_valid),
  .out_i    (out_i),
  .out_q    (out_q),
  .take     (take_w),
  .restart  (sel_changed_w)
);

// File: tb/rx_skip_decim_tb_top.sv
`timescale 1ns/1ps
module rx_skip_decim_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_i = '0;
  logic [W-1:0] in_q = '0;
  logic [2:0]   dec_sel = 3'b111;
  logic         out_valid;
  logic [W-1:0] out_i;
  logic [W-1:0] out_q;

  always #10 clk = ~clk;

  rx_skip_decim #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .dec_sel(dec_sel), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // Reference model state: pairs seen since the last phase restart.
  int           ref_since = 0;
  logic [2:0]   ref_prev_sel = 3'b111;
  bit           pending = 0;
  bit           exp_v;
  logic [W-1:0] exp_i, exp_q;
  string        exp_tag;
  int           seq = 1;

  task automatic check_pending();
    if (!pending) return;
    n_checks++;
    if (out_valid !== exp_v) begin
      n_fails++;
      $display("FAIL %s: out_valid=%0b expected %0b", exp_tag, out_valid, exp_v);
    end else if (exp_v && (out_i !== exp_i || out_q !== exp_q)) begin
      n_fails++;
      $display("FAIL %s: out_i=%0h out_q=%0h expected %0h %0h", exp_tag, out_i, out_q, exp_i, exp_q);
    end
  endtask

  // One clock: check the previous result, drive a new pair, predict the result.
  task automatic step(input bit v, input logic [2:0] sel, input string tag);
    int n;
    logic [W-1:0] di, dq;
    @(negedge clk);
    check_pending();
    di = W'(seq * 37 + 5);
    dq = W'(seq * 91 + 1000);
    seq++;
    in_valid = v; in_i = di; in_q = dq; dec_sel = sel;
    n = 8 - int'(sel);
    if (sel != ref_prev_sel) ref_since = 0;
    ref_prev_sel = sel;
    exp_v = v && (ref_since % n == 0);
    if (v) ref_since++;
    exp_i = di; exp_q = dq;
    exp_tag = tag;
    pending = 1;
  endtask

  task automatic do_reset(input logic [2:0] sel);
    @(negedge clk);
    check_pending();
    pending = 0;
    rst = 1; in_valid = 0; dec_sel = sel;
    repeat (3) @(negedge clk);
    rst = 0;
    ref_since = 0; ref_prev_sel = sel;
    n_checks++;                                   // R1 reset state
    if (out_valid !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: out_valid=%0b expected 0", out_valid);
    end
  endtask

  task automatic t_reset();                        // R1
    do_reset(3'b000);
    step(1, 3'b000, "R1");
    step(1, 3'b000, "R1");
  endtask

  task automatic t_full();                         // R2
    for (int k = 0; k < 10; k++) step(1, 3'b111, "R2");
  endtask

  task automatic t_half();                         // R3
    for (int k = 0; k < 10; k++) step(1, 3'b110, "R3");
  endtask

  task automatic t_third();                        // R4
    for (int k = 0; k < 12; k++) step(1, 3'b101, "R4");
  endtask

  task automatic t_eighth();                       // R5
    for (int k = 0; k < 20; k++) step(1, 3'b000, "R5");
  endtask

  task automatic t_sweep();                        // R6
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 18; k++) step(1, 3'(c), "R6");
  endtask

  task automatic t_gaps();                         // R7
    for (int k = 0; k < 24; k++) step((k % 3) != 1, 3'b101, "R7");
    for (int k = 0; k < 16; k++) step((k % 2) == 0, 3'b011, "R7");
  endtask

  task automatic t_change();                       // R8, R9
    for (int k = 0; k < 3; k++) step(1, 3'b000, "R8");
    step(1, 3'b100, "R8");                         // mid-phase change, forwarded
    for (int k = 0; k < 5; k++) step(1, 3'b100, "R8");
    step(0, 3'b010, "R8");                         // change during an idle cycle
    for (int k = 0; k < 8; k++) step(1, 3'b010, "R8");
    for (int k = 0; k < 6; k++) step(1, 3'b110 ^ 3'(k & 1), "R9");
    step(0, 3'b111, "R9");
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_full();
    t_half();
    t_third();
    t_eighth();
    t_sweep();
    t_gaps();
    t_change();
    do_reset(3'b110);
    step(1, 3'b110, "R1");
    step(1, 3'b110, "R1");
    step(0, 3'b110, "R7");
    @(negedge clk);
    check_pending();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule